// File: doc/BRIEF.md
# Long-Word Byte Swap and Bus Sizer

This block connects a 36-bit word store to an external port whose data bus can be used at full width, half width or a single byte. A long word holds four 9-bit byte lanes: lane 0 at [8:0], lane 1 at [17:9], lane 2 at [26:18] and lane 3 at [35:27]. The block can reorder those lanes, and it can cut a word into narrower pieces or build a word from them.

On the read path, the head word presented by the store is byte-swapped first. The swapped word is then sent to the port one piece per request, most significant piece first. The block raises a completion strobe on the final piece so that the store can advance. On the write path, pieces arriving from the port are assembled into a long word, most significant piece first. The swap is applied to the assembled word as it is handed to the store, together with a write strobe. The swap select and the size select are both sampled when a word begins, and they are held until that word is complete.

Each path runs its own two-state machine. PH_IDLE means no word is in progress, and PH_MID means part of a word has been transferred. The transitions are as follows:
- PH_IDLE to PH_IDLE: no request, or a single-piece (36-bit) word.
- PH_IDLE to PH_MID: the first piece of a narrow word.
- PH_MID to PH_MID: a middle piece, or a cycle with no request.
- PH_MID to PH_IDLE: the final piece.

Top module: `lword_swap_sizer`

## Requirements
- R1: The swap select code 00 leaves the lanes unchanged. Code 01 reverses all lanes (output lane j takes input lane 3-j). Code 10 exchanges the halves (output lane j takes input lane (j+2) mod 4). Code 11 exchanges the two lanes within each half (output lane j takes input lane j xor 1). Bits inside a lane never move.
- R2: The size select code 00 gives 36-bit pieces (one per word). Code 01 gives 18-bit pieces in bits [17:0] (two per word). Codes 10 and 11 give 9-bit pieces in bits [8:0] (four per word). Read pieces carry zeros above the piece width, and write input bits above the piece width are ignored.
- R3: Swap select and size select are sampled only on the request that starts a word. Changes on either select during later pieces of that word have no effect, and neither do changes of the store's read word.
- R4: On a read, piece k of an n-piece word is bits [(n-k)*w-1 : (n-1-k)*w] of the swapped word, where w is the piece width. It appears on port_rd_data on the clock edge that samples the request.
- R5: On a write, the pieces are concatenated most significant first, and st_wr_word equals the selected swap applied to that concatenation in the cycle st_wr_en is high.
- R6: rd_adv is high exactly in a cycle whose read request carries the final piece of a word. st_wr_en is high exactly in a cycle whose write request carries the final piece.
- R7: A cycle without a request leaves port_rd_data and the word progress unchanged, and raises no strobe.
- R8: After reset, both paths are in PH_IDLE, port_rd_data is zero and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_sel | input | 2 | Lane order code, sampled at word start |
| size_sel | input | 2 | Bus width code, sampled at word start |
| rd_req | input | 1 | Port reads one piece this cycle |
| st_rd_word | input | 36 | Head word offered by the store |
| rd_adv | output | 1 | Final read piece taken; store advances |
| port_rd_data | output | 36 | Registered read piece to the port |
| wr_req | input | 1 | Port writes one piece this cycle |
| port_wr_data | input | 36 | Write piece from the port |
| st_wr_en | output | 1 | Assembled word is delivered to the store |
| st_wr_word | output | 36 | Swapped assembled word for the store |

## Verification
Every swap code is crossed with every size code, including the alias code 11 for byte mode. Each combination is tried with a word whose lanes are all distinct, so a lane taken from the wrong place shows up at once, and with random words that catch a bit moved inside a lane. Between pieces, the bench drives the opposite selects and a junk store word, and it fills the unused upper write bits with noise; these separate a design that holds its sampled state from one that follows live inputs. Idle cycles inserted inside words show whether the output and the piece count stay put while no request is made.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        BUS_W36 = 2'd0,
        BUS_W18 = 2'd1,
        BUS_W9  = 2'd2
    } bus_mode_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_MID  = 1'b1
    } phase_e;

    function automatic bus_mode_e decode_mode(input logic [1:0] sel);
        if (sel[1])      return BUS_W9;
        else if (sel[0]) return BUS_W18;
        else             return BUS_W36;
    endfunction

    function automatic int unsigned piece_count(input bus_mode_e m);
        unique case (m)
            BUS_W36: return 1;
            BUS_W18: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int unsigned piece_bits(input bus_mode_e m, input int unsigned lane_w);
        return (lane_w * LANES) / piece_count(m);
    endfunction

endpackage

// File: rtl/lws_lane_swap.sv
module lws_lane_swap
    import lws_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  logic [LANE_W*LANES-1:0] din,
    input  logic [1:0]              sel,
    output logic [LANE_W*LANES-1:0] dout
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int unsigned SRC_REV  = LANES - 1 - j;
        localparam int unsigned SRC_HALF = (j + LANES / 2) % LANES;
        localparam int unsigned SRC_PAIR = j ^ 1;
        logic [LANE_W-1:0] lane_out;

        always_comb begin
            unique case (sel)
                2'b00: lane_out = din[j*LANE_W +: LANE_W];
                2'b01: lane_out = din[SRC_REV*LANE_W +: LANE_W];
                2'b10: lane_out = din[SRC_HALF*LANE_W +: LANE_W];
                2'b11: lane_out = din[SRC_PAIR*LANE_W +: LANE_W];
            endcase
        end

        assign dout[j*LANE_W +: LANE_W] = lane_out;
    end

endmodule

// File: rtl/lws_rd_path.sv
module lws_rd_path
    import lws_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              swap_sel,
    input  logic [1:0]              size_sel,
    input  logic                    rd_req,
    input  logic [LANE_W*LANES-1:0] st_word,
    output logic                    rd_adv,
    output logic [LANE_W*LANES-1:0] rd_data
);

    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned CNT_W  = $clog2(LANES);

    phase_e              phase_q, phase_d;
    bus_mode_e           mode_q, cur_mode;
    logic [WORD_W-1:0]   word_q, swapped, cur_word;
    logic [CNT_W-1:0]    cnt_q, cur_idx;
    logic                last;

    function automatic logic [WORD_W-1:0] take_piece(input logic [WORD_W-1:0] w,
                                                     input bus_mode_e m,
                                                     input logic [CNT_W-1:0] idx);
        int unsigned pw, sh;
        pw = piece_bits(m, LANE_W);
        sh = (piece_count(m) - 1 - int'(idx)) * pw;
        return (w >> sh) & ({WORD_W{1'b1}} >> (WORD_W - pw));
    endfunction

    lws_lane_swap #(.LANE_W(LANE_W)) u_swap (
        .din  (st_word),
        .sel  (swap_sel),
        .dout (swapped)
    );

    always_comb begin
        unique case (phase_q)
            PH_IDLE: begin
                cur_mode = decode_mode(size_sel);
                cur_word = swapped;
                cur_idx  = '0;
            end
            PH_MID: begin
                cur_mode = mode_q;
                cur_word = word_q;
                cur_idx  = cnt_q;
            end
        endcase
        last    = (cur_idx == CNT_W'(piece_count(cur_mode) - 1));
        rd_adv  = rd_req && last;
        phase_d = phase_q;
        if (rd_req) phase_d = last ? PH_IDLE : PH_MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            word_q  <= '0;
            mode_q  <= BUS_W36;
            cnt_q   <= '0;
        end else if (rd_req) begin
            rd_data <= take_piece(cur_word, cur_mode, cur_idx);
            cnt_q   <= last ? '0 : cur_idx + 1'b1;
            if (phase_q == PH_IDLE) begin
                word_q <= swapped;
                mode_q <= cur_mode;
            end
        end
    end

    p_adv_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> rd_req);
    p_adv_ends_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> phase_q == PH_IDLE);
    p_word_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_MID |=> $stable(word_q) && $stable(mode_q));
    p_full_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_MID |-> mode_q != BUS_W36 && cnt_q != '0);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data) && $stable(phase_q));

endmodule

// File: rtl/lws_wr_path.sv
module lws_wr_path
    import lws_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              swap_sel,
    input  logic [1:0]              size_sel,
    input  logic                    wr_req,
    input  logic [LANE_W*LANES-1:0] wr_data,
    output logic                    st_en,
    output logic [LANE_W*LANES-1:0] st_word
);

    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned CNT_W  = $clog2(LANES);

    phase_e              phase_q, phase_d;
    bus_mode_e           mode_q, cur_mode;
    logic [1:0]          swap_q, cur_swap;
    logic [WORD_W-1:0]   acc_q, piece, joined;
    logic [CNT_W-1:0]    cnt_q, cur_idx;
    logic                last;
    int unsigned         pw;

    always_comb begin
        unique case (phase_q)
            PH_IDLE: begin
                cur_mode = decode_mode(size_sel);
                cur_swap = swap_sel;
                cur_idx  = '0;
            end
            PH_MID: begin
                cur_mode = mode_q;
                cur_swap = swap_q;
                cur_idx  = cnt_q;
            end
        endcase
        pw      = piece_bits(cur_mode, LANE_W);
        piece   = wr_data & ({WORD_W{1'b1}} >> (WORD_W - pw));
        joined  = (phase_q == PH_IDLE) ? piece : ((acc_q << pw) | piece);
        last    = (cur_idx == CNT_W'(piece_count(cur_mode) - 1));
        st_en   = wr_req && last;
        phase_d = phase_q;
        if (wr_req) phase_d = last ? PH_IDLE : PH_MID;
    end

    lws_lane_swap #(.LANE_W(LANE_W)) u_swap (
        .din  (joined),
        .sel  (cur_swap),
        .dout (st_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mode_q <= BUS_W36;
            swap_q <= 2'b00;
            cnt_q  <= '0;
        end else if (wr_req) begin
            acc_q <= joined;
            cnt_q <= last ? '0 : cur_idx + 1'b1;
            if (phase_q == PH_IDLE) begin
                mode_q <= cur_mode;
                swap_q <= swap_sel;
            end
        end
    end

    p_wr_en_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> wr_req);
    p_wr_en_ends_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> phase_q == PH_IDLE);
    p_wr_sel_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_MID |=> $stable(swap_q) && $stable(mode_q));
    p_wr_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(acc_q) && $stable(cnt_q) && $stable(phase_q));

endmodule

// File: rtl/lword_swap_sizer.sv
module lword_swap_sizer
    import lws_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              swap_sel,
    input  logic [1:0]              size_sel,
    input  logic                    rd_req,
    input  logic [LANE_W*LANES-1:0] st_rd_word,
    output logic                    rd_adv,
    output logic [LANE_W*LANES-1:0] port_rd_data,
    input  logic                    wr_req,
    input  logic [LANE_W*LANES-1:0] port_wr_data,
    output logic                    st_wr_en,
    output logic [LANE_W*LANES-1:0] st_wr_word
);

    lws_rd_path #(.LANE_W(LANE_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_sel (swap_sel),
        .size_sel (size_sel),
        .rd_req   (rd_req),
        .st_word  (st_rd_word),
        .rd_adv   (rd_adv),
        .rd_data  (port_rd_data)
    );

    lws_wr_path #(.LANE_W(LANE_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_sel (swap_sel),
        .size_sel (size_sel),
        .wr_req   (wr_req),
        .wr_data  (port_wr_data),
        .st_en    (st_wr_en),
        .st_word  (st_wr_word)
    );

    p_strobe_quiet_in_reset_r8: assert property (@(posedge clk)
        !rst_n |-> !rd_adv || rd_req);

endmodule

// File: tb/tb_lword_swap_sizer.sv
module tb_lword_swap_sizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  swap_sel = 2'b00;
    logic [1:0]  size_sel = 2'b00;
    logic        rd_req = 1'b0;
    logic [35:0] st_rd_word = '0;
    logic        rd_adv;
    logic [35:0] port_rd_data;
    logic        wr_req = 1'b0;
    logic [35:0] port_wr_data = '0;
    logic        st_wr_en;
    logic [35:0] st_wr_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    lword_swap_sizer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_sel     (swap_sel),
        .size_sel     (size_sel),
        .rd_req       (rd_req),
        .st_rd_word   (st_rd_word),
        .rd_adv       (rd_adv),
        .port_rd_data (port_rd_data),
        .wr_req       (wr_req),
        .port_wr_data (port_wr_data),
        .st_wr_en     (st_wr_en),
        .st_wr_word   (st_wr_word)
    );

    task automatic check(input logic [35:0] act, input logic [35:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1 model: output lane j takes input lane j xor m, m from the code
    function automatic logic [35:0] model_swap(input logic [35:0] w, input logic [1:0] sel);
        logic [35:0] r;
        int m;
        m = (sel == 2'd0) ? 0 : (sel == 2'd1) ? 3 : (sel == 2'd2) ? 2 : 1;
        for (int j = 0; j < 4; j++) r[j*9 +: 9] = w[(j ^ m)*9 +: 9];
        return r;
    endfunction

    function automatic int n_of(input logic [1:0] sz);
        return sz[1] ? 4 : (sz[0] ? 2 : 1);
    endfunction

    function automatic logic [35:0] mask_of(input int pw);
        return {36{1'b1}} >> (36 - pw);
    endfunction

    task automatic read_word(input logic [35:0] w, input logic [1:0] sw,
                             input logic [1:0] sz, input bit stall);
        int n, pw;
        logic [35:0] sww, exp_p, held;
        n = n_of(sz); pw = 36 / n; sww = model_swap(w, sw);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_req     = 1'b1;
            st_rd_word = (k == 0) ? w : 36'({$urandom(), $urandom()});
            swap_sel   = (k == 0) ? sw : ~sw;
            size_sel   = (k == 0) ? sz : sz ^ 2'b11;
            #2 check({35'd0, rd_adv}, {35'd0, k == n - 1}, "R6 rd_adv");
            @(posedge clk); #2;
            exp_p = (sww >> ((n - 1 - k) * pw)) & mask_of(pw);
            check(port_rd_data, exp_p, (k == 0) ? "R1/R4 read piece" : "R3/R2 read piece");
            if (stall && k < n - 1) begin
                held = port_rd_data;
                @(negedge clk);
                rd_req = 1'b0; swap_sel = ~sw; size_sel = ~sz;
                #2 check({35'd0, rd_adv}, 36'd0, "R7 rd_adv idle");
                @(posedge clk); #2;
                check(port_rd_data, held, "R7 read hold");
            end
        end
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic write_word(input logic [35:0] w, input logic [1:0] sw,
                              input logic [1:0] sz, input bit stall);
        int n, pw;
        logic [35:0] pc, junk;
        n = n_of(sz); pw = 36 / n;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pc   = (w >> ((n - 1 - k) * pw)) & mask_of(pw);
            junk = 36'({$urandom(), $urandom()}) & ~mask_of(pw);
            wr_req       = 1'b1;
            port_wr_data = pc | junk;
            swap_sel     = (k == 0) ? sw : ~sw;
            size_sel     = (k == 0) ? sz : sz ^ 2'b11;
            #2 check({35'd0, st_wr_en}, {35'd0, k == n - 1}, "R6 st_wr_en");
            if (k == n - 1) check(st_wr_word, model_swap(w, sw), "R5/R1 write word");
            if (stall && k < n - 1) begin
                @(negedge clk);
                wr_req = 1'b0; swap_sel = ~sw;
                #2 check({35'd0, st_wr_en}, 36'd0, "R7 st_wr_en idle");
            end
        end
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [35:0] words [3];
        bit st;
        words[0] = {9'h1A3, 9'h0C5, 9'h1F0, 9'h03E};
        repeat (3) @(negedge clk);
        check(port_rd_data, 36'd0, "R8 reset data");
        check({34'd0, rd_adv, st_wr_en}, 36'd0, "R8 reset strobes");
        rst_n = 1'b1;
        @(negedge clk);
        check(port_rd_data, 36'd0, "R8 data after reset");
        st = 1'b0;
        for (int sw = 0; sw < 4; sw++) begin
            for (int sz = 0; sz < 4; sz++) begin
                words[1] = 36'({$urandom(), $urandom()});
                words[2] = 36'({$urandom(), $urandom()});
                for (int i = 0; i < 3; i++) begin
                    st = ~st;
                    read_word(words[i], 2'(sw), 2'(sz), st);
                    write_word(words[i], 2'(sw), 2'(sz), st);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule